// File: doc/BRIEF.md
# Fan Tachometer Measurement Unit

This block measures how fast a fan turns by watching its tachometer pulse train. Software enables it through four word registers and chooses one of two measurement styles. In period style, the block counts ticks of a slow reference enable between a rising tach edge and a later rising edge 1, 2, 4 or 8 periods on. In frequency style, it counts rising tach edges inside a fixed window of reference ticks. Each finished measurement is placed in a read-only field, and the block checks it against a programmable 16-bit low/high window.

The tach input passes through a two-flop synchronizer. An optional majority-free noise filter follows, which accepts a new level only after a run of equal samples taken on the reference enable. Three sticky event flags record out-of-window results, finished measurements and changes of the tach level. Each flag has its own interrupt enable, and the enabled flags merge into one interrupt line.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset, the control word (address 0) reads 0, the status word (address 1) reads 0, the low limit (address 2) reads 0x0000, the high limit (address 3) reads 0xFFFF and `irq` is low.
- R2: With control bit 2 set (period style), the result equals the number of reference ticks between a rising tach edge and the rising edge N periods later, where N = 1, 2, 4 or 8 for control bits [4:3] = 0..3. Consecutive intervals share their boundary edge. The result reads back in control bits [31:16].
- R3: With control bit 2 clear (frequency style), the result equals the number of rising tach edges seen during a window of WINDOW_TICKS reference ticks.
- R4: The result saturates at 0xFFFF instead of wrapping.
- R5: Each finished measurement sets the ready flag (status bit 1). The result field changes only when a measurement finishes.
- R6: A result below the low limit or above the high limit sets the out-of-window flag (status bit 0). A result equal to either limit does not set it.
- R7: Every accepted change of the tach level sets the toggle flag (status bit 2). This happens whether or not measurement is enabled.
- R8: With control bit 1 set, a new tach level is accepted only after FILT_DEPTH equal consecutive samples taken on the reference tick. A shorter pulse is ignored.
- R9: Writing the status word clears each flag whose data bit is 1 and leaves the others untouched.
- R10: `irq` is high exactly when some flag is set and its enable is set. The enables are control bit 5 for out-of-window, bit 6 for ready and bit 7 for toggle.
- R11: While control bit 0 (enable) is clear, no measurement finishes and the result field holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable marking each slow reference tick |
| tach_in | input | 1 | Asynchronous fan tachometer input |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 control, 1 status, 2 low limit, 3 high limit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Merged interrupt request |

## Verification
The bench builds the block with WINDOW_TICKS = 16 instead of 256. This keeps a frequency-style window at 64 clocks when a tick comes every fourth cycle, so several windows finish in a short run. Filter depth and synchronizer length stay at their defaults, 3 and 2. The saturation case uses a tick on every clock with a 70,000-cycle tach period, which pushes a single-period count past 16 bits in a reachable time. The bench also changes the tick spacing between cases (1, 2 and 4 clocks) so that results depend on the reference rate.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_STATUS = 2'd1,
        ADDR_LO     = 2'd2,
        ADDR_HI     = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       ien_tog;
        logic       ien_rdy;
        logic       ien_ool;
        logic [1:0] span_sel;
        logic       ref_mode;
        logic       filt_en;
        logic       enable;
    } ctrl_t;

    typedef struct packed {
        logic tog;
        logic rdy;
        logic ool;
    } stat_t;

    function automatic logic [3:0] span_periods(input logic [1:0] sel);
        return 4'd1 << sel;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v, input logic inc);
        logic [CNT_W:0] sum;
        sum = {1'b0, v} + {{CNT_W{1'b0}}, inc};
        return sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/fan_tach_input.sv
module fan_tach_input #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_DEPTH  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tach_i,
    input  logic tick_i,
    input  logic filt_en_i,
    output logic rise_o,
    output logic toggle_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_DEPTH-1:0]  hist_q;
    logic                   lvl_q, prev_q, lvl_d, raw;

    assign raw = sync_q[SYNC_STAGES-1];

    always_comb begin
        lvl_d = raw;
        if (filt_en_i) begin
            if (&hist_q)       lvl_d = 1'b1;
            else if (~|hist_q) lvl_d = 1'b0;
            else               lvl_d = lvl_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= '0;
            lvl_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], tach_i};
            if (tick_i) hist_q <= {hist_q[FILT_DEPTH-2:0], raw};
            lvl_q  <= lvl_d;
            prev_q <= lvl_q;
        end
    end

    assign rise_o   = lvl_q & ~prev_q;
    assign toggle_o = lvl_q ^ prev_q;
endmodule

// File: rtl/fan_tach_counter.sv
module fan_tach_counter
    import fan_tach_pkg::*;
#(
    parameter int WINDOW_TICKS = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             ref_mode_i,
    input  logic [1:0]       span_sel_i,
    input  logic             tick_i,
    input  logic             rise_i,
    output logic             done_o,
    output logic [CNT_W-1:0] value_o
);
    localparam int WIN_W = (WINDOW_TICKS > 2) ? $clog2(WINDOW_TICKS) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_TICKS - 1);

    logic             armed_q;
    logic [3:0]       edges_q;
    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] cnt_q, tick_sum, edge_sum;

    assign tick_sum = sat_inc(cnt_q, tick_i);
    assign edge_sum = sat_inc(cnt_q, rise_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            edges_q <= '0;
            win_q   <= '0;
            cnt_q   <= '0;
            done_o  <= 1'b0;
            value_o <= '0;
        end else if (!enable_i) begin
            armed_q <= 1'b0;
            edges_q <= '0;
            win_q   <= '0;
            cnt_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (ref_mode_i) begin
                if (rise_i) begin
                    if (!armed_q) begin
                        armed_q <= 1'b1;
                        edges_q <= '0;
                        cnt_q   <= '0;
                    end else if (edges_q + 4'd1 == span_periods(span_sel_i)) begin
                        done_o  <= 1'b1;
                        value_o <= tick_sum;
                        edges_q <= '0;
                        cnt_q   <= '0;
                    end else begin
                        edges_q <= edges_q + 4'd1;
                        cnt_q   <= tick_sum;
                    end
                end else if (armed_q) begin
                    cnt_q <= tick_sum;
                end
            end else begin
                if (tick_i && win_q == WIN_LAST) begin
                    done_o  <= 1'b1;
                    value_o <= edge_sum;
                    win_q   <= '0;
                    cnt_q   <= '0;
                end else begin
                    if (tick_i) win_q <= win_q + 1'b1;
                    cnt_q <= edge_sum;
                end
            end
        end
    end
endmodule

// File: rtl/fan_tach_regs.sv
module fan_tach_regs
    import fan_tach_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [15:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             done_i,
    input  logic [CNT_W-1:0] value_i,
    input  logic             toggle_i,
    output ctrl_t            ctrl_o,
    output stat_t            stat_o,
    output logic [CNT_W-1:0] result_o,
    output logic [15:0]      lim_lo_o,
    output logic [15:0]      lim_hi_o,
    output logic             irq_o
);
    stat_t set_v, clr_v;
    logic  out_of_window;

    assign out_of_window = (value_i < lim_lo_o) || (value_i > lim_hi_o);
    assign set_v = '{tog: toggle_i, rdy: done_i, ool: done_i & out_of_window};
    assign clr_v = (bus_wr && bus_addr == ADDR_STATUS) ? stat_t'(bus_wdata[2:0]) : stat_t'(3'b000);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o   <= '0;
            stat_o   <= '0;
            result_o <= '0;
            lim_lo_o <= 16'h0000;
            lim_hi_o <= 16'hFFFF;
        end else begin
            stat_o <= (stat_o & ~clr_v) | set_v;
            if (done_i) result_o <= value_i;
            if (bus_wr) begin
                case (bus_addr)
                    ADDR_CTRL: ctrl_o   <= ctrl_t'(bus_wdata[7:0]);
                    ADDR_LO:   lim_lo_o <= bus_wdata;
                    ADDR_HI:   lim_hi_o <= bus_wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL:   bus_rdata = {result_o, 8'h00, ctrl_o};
            ADDR_STATUS: bus_rdata = {29'd0, stat_o};
            ADDR_LO:     bus_rdata = {16'd0, lim_lo_o};
            default:     bus_rdata = {16'd0, lim_hi_o};
        endcase
    end

    assign irq_o = |(stat_o & {ctrl_o.ien_tog, ctrl_o.ien_rdy, ctrl_o.ien_ool});
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
    import fan_tach_pkg::*;
#(
    parameter int WINDOW_TICKS = 256,
    parameter int SYNC_STAGES  = 2,
    parameter int FILT_DEPTH   = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_tick,
    input  logic        tach_in,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    ctrl_t            ctrl;
    stat_t            stat;
    logic             rise, toggle, done;
    logic [CNT_W-1:0] value, result;
    logic [15:0]      lim_lo, lim_hi;

    fan_tach_input #(.SYNC_STAGES(SYNC_STAGES), .FILT_DEPTH(FILT_DEPTH)) u_input (
        .clk(clk), .rst(rst), .tach_i(tach_in), .tick_i(ref_tick),
        .filt_en_i(ctrl.filt_en), .rise_o(rise), .toggle_o(toggle)
    );

    fan_tach_counter #(.WINDOW_TICKS(WINDOW_TICKS)) u_counter (
        .clk(clk), .rst(rst), .enable_i(ctrl.enable), .ref_mode_i(ctrl.ref_mode),
        .span_sel_i(ctrl.span_sel), .tick_i(ref_tick), .rise_i(rise),
        .done_o(done), .value_o(value)
    );

    fan_tach_regs u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_i(done),
        .value_i(value), .toggle_i(toggle), .ctrl_o(ctrl), .stat_o(stat),
        .result_o(result), .lim_lo_o(lim_lo), .lim_hi_o(lim_hi), .irq_o(irq)
    );
endmodule

// File: rtl/fan_tach_meter_chk.sv
module fan_tach_meter_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        irq,
    input logic        en,
    input logic [2:0]  ien,
    input logic [2:0]  stat,
    input logic        done,
    input logic [15:0] value,
    input logic [15:0] result,
    input logic [15:0] lim_lo,
    input logic [15:0] lim_hi
);
    logic stat_wr;
    assign stat_wr = bus_wr && bus_addr == 2'd1;

    p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> ien != 3'b000);

    p_ready_follows_done_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> stat[1]);

    p_result_holds_r5: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(result));

    p_ool_flag_r6: assert property (@(posedge clk) disable iff (rst)
        done && (value < lim_lo || value > lim_hi) |=> stat[0]);

    p_ool_quiet_in_window_r6: assert property (@(posedge clk) disable iff (rst)
        done && value >= lim_lo && value <= lim_hi && !stat[0] |=> !stat[0]);

    p_idle_when_off_r11: assert property (@(posedge clk) disable iff (rst)
        !en && !$past(en) |-> !done);

    p_w1c_ready_r9: assert property (@(posedge clk) disable iff (rst)
        stat_wr && bus_wdata[1] && !done |=> !stat[1]);
endmodule

bind fan_tach_meter fan_tach_meter_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq(irq), .en(ctrl.enable),
    .ien({ctrl.ien_tog, ctrl.ien_rdy, ctrl.ien_ool}), .stat(stat),
    .done(done), .value(value), .result(result),
    .lim_lo(lim_lo), .lim_hi(lim_hi)
);

// File: tb/fan_tach_meter_tb_top.sv
module fan_tach_meter_tb_top;
    localparam int WIN = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        tach_gen = 1'b0;
    logic        glitch = 1'b0;
    logic        tach_in;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_div = 4;
    int half_set = 0;
    int exp_q[$];
    int ool_q[$];

    assign tach_in = tach_gen | glitch;

    always #10 clk = ~clk;

    fan_tach_meter #(.WINDOW_TICKS(WIN)) dut_i (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .tach_in(tach_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc++;
            if (tc >= tick_div) begin tc = 0; ref_tick = 1'b1; end
            else ref_tick = 1'b0;
        end
    end

    initial begin
        int hc = 0;
        forever begin
            @(negedge clk);
            if (half_set == 0) begin tach_gen = 1'b0; hc = 0; end
            else begin
                hc++;
                if (hc >= half_set) begin hc = 0; tach_gen = ~tach_gen; end
            end
        end
    end

    task automatic check(string req, longint act, longint exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp_v);
        end
    endtask

    task automatic bus_write(input int a, input int d);
        @(negedge clk);
        bus_addr = 2'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        bus_addr = 2'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_irq();
        @(negedge clk);
        while (!irq) @(negedge clk);
    endtask

    // driver pushes expected results, monitor pops them as the block reports
    task automatic run_case(string req, bit refm, bit filt, int sel, int div, int half,
                            int lo, int hi, int skip, int nres, int expc);
        half_set = 0;
        bus_write(0, 0);
        bus_write(2, lo);
        bus_write(3, hi);
        tick_div = div;
        repeat (40) @(negedge clk);
        bus_write(1, 7);
        bus_write(0, 1 | (int'(filt) << 1) | (int'(refm) << 2) | (sel << 3) | (1 << 6));
        half_set = half;
        repeat (skip) begin wait_irq(); bus_write(1, 3); end
        fork
            begin
                for (int i = 0; i < nres; i++) begin
                    exp_q.push_back(expc);
                    ool_q.push_back((expc < lo || expc > hi) ? 1 : 0);
                end
            end
            begin
                for (int i = 0; i < nres; i++) begin
                    logic [31:0] c, s;
                    wait_irq();
                    bus_read(0, c);
                    bus_read(1, s);
                    while (exp_q.size() == 0) @(negedge clk);
                    check({req, " result"}, c[31:16], exp_q.pop_front());
                    check({req, " R6 window flag"}, s[0], ool_q.pop_front());
                    bus_write(1, 3);
                end
            end
        join
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [15:0] held;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(0, r); check("R1 ctrl", r, 0);
        bus_read(1, r); check("R1 status", r, 0);
        bus_read(2, r); check("R1 low limit", r, 16'h0000);
        bus_read(3, r); check("R1 high limit", r, 16'hFFFF);
        check("R1 irq", irq, 0);

        // R2 period style: N*period/tick_div
        run_case("R2 sel0", 1, 0, 0, 4, 8, 0, 16'hFFFF, 1, 2, 4);
        run_case("R2 sel2", 1, 0, 2, 2, 12, 0, 16'hFFFF, 1, 2, 48);
        run_case("R2 sel3", 1, 0, 3, 4, 4, 0, 16'hFFFF, 1, 2, 16);
        // R3 frequency style: WIN*tick_div/period
        run_case("R3 p16", 0, 0, 0, 4, 8, 0, 16'hFFFF, 1, 2, (WIN * 4) / 16);
        run_case("R3 p8", 0, 0, 0, 4, 4, 0, 16'hFFFF, 1, 2, (WIN * 4) / 8);
        // R6 limit window, result 4
        run_case("R6 below", 1, 0, 0, 4, 8, 5, 16'hFFFF, 1, 1, 4);
        run_case("R6 equal", 1, 0, 0, 4, 8, 4, 4, 1, 1, 4);
        run_case("R6 above", 1, 0, 0, 4, 8, 0, 3, 1, 1, 4);
        // R8 filtered clean input gives the unfiltered count
        run_case("R8 filtered", 1, 1, 1, 4, 32, 0, 16'hFFFF, 1, 2, 32);
        // R4 saturation: 70000 ticks in one period
        run_case("R4 saturate", 1, 0, 0, 1, 35000, 0, 16'hFFFF, 0, 1, 16'hFFFF);

        // R11 disabled: nothing completes, result holds
        half_set = 0;
        bus_write(0, 0);
        tick_div = 4;
        bus_read(0, r); held = r[31:16];
        bus_write(0, 1 << 6);
        half_set = 8;
        bus_write(1, 7);
        repeat (400) @(negedge clk);
        bus_read(1, r); check("R11 no ready", r[1], 0);
        bus_read(0, r); check("R11 result held", r[31:16], held);
        check("R11 irq", irq, 0);

        // R9 / R10 flag clearing and interrupt merge
        half_set = 0;
        bus_write(0, 0);
        bus_write(2, 100);
        bus_write(3, 16'hFFFF);
        repeat (20) @(negedge clk);
        bus_write(1, 7);
        bus_write(0, 1 | (1 << 2) | (1 << 6));
        half_set = 8;
        wait_irq();
        half_set = 0;
        repeat (100) @(negedge clk);
        bus_write(0, 0);
        bus_read(1, r); check("R9 all flags set", r[2:0], 3'b111);
        bus_write(1, 1);
        bus_read(1, r); check("R9 clear window flag only", r[2:0], 3'b110);
        bus_write(1, 4);
        bus_read(1, r); check("R9 clear toggle only", r[2:0], 3'b010);
        bus_write(0, 1 << 6);
        @(negedge clk); check("R10 ready enabled", irq, 1);
        bus_write(0, 1 << 5);
        @(negedge clk); check("R10 window flag clear", irq, 0);
        bus_write(0, 1 << 7);
        @(negedge clk); check("R10 toggle flag clear", irq, 0);
        bus_write(1, 16'hFFFF);
        bus_read(1, r); check("R9 clear all", r[2:0], 3'b000);
        bus_write(0, 0);

        // R8 short pulse filtered out, R7 long pulse and unfiltered pulse seen
        bus_write(0, 1 << 1);
        repeat (40) @(negedge clk);
        bus_write(1, 7);
        glitch = 1'b1; repeat (6) @(negedge clk); glitch = 1'b0;
        repeat (40) @(negedge clk);
        bus_read(1, r); check("R8 short pulse ignored", r[2], 0);
        glitch = 1'b1; repeat (40) @(negedge clk); glitch = 1'b0;
        repeat (40) @(negedge clk);
        bus_read(1, r); check("R7 filtered level change", r[2], 1);
        bus_write(0, 0);
        repeat (10) @(negedge clk);
        bus_write(1, 7);
        glitch = 1'b1; repeat (6) @(negedge clk); glitch = 1'b0;
        repeat (10) @(negedge clk);
        bus_read(1, r); check("R7 unfiltered pulse", r[2], 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule